// File: doc/BRIEF.md
# Atomic Fetch-and-Add Counter Bank

This block is a bank of atomic counters held in a 2048-byte store. Any aligned 1, 2, 4 or 8 byte slice of the store can be treated as a counter. Each slice is placed big-endian inside its 8-byte word. Requesters issue one operation per clock on a simple request port.

A fetch-and-add operation adds a 22-bit signed increment and returns the previous value one cycle later on the response port. A store-type operation carries full-width data. Depending on a mode bit, it either adds that data to the selected counter or overwrites the counter with it, and it gives no response.

Misaligned requests are refused with an error response. Because each read-modify-write finishes inside the cycle it is accepted, an operation in the next cycle on the same or an overlapping slice always sees the updated contents.

Top module: `fau_regfile`

## Requirements
- R1: After reset every byte of the store reads as zero.
- R2: A fetch-and-add request (req_store=0) produces, exactly one cycle later, rsp_valid=1 with rsp_err=0 and rsp_old equal to the previous counter value sign-extended from the operand width to 64 bits. The counter then holds previous value plus increment.
- R3: The fetch-and-add increment is req_operand[21:0], sign-extended to the operand width. req_operand[63:22] has no effect, and req_mode has no effect on fetch-and-add.
- R4: A store request (req_store=1) with req_mode=0 adds the low bytes of req_operand (as many as the operand width) to the counter and produces no response.
- R5: A store request with req_mode=1 replaces the counter with the low bytes of req_operand and produces no response.
- R6: All additions wrap modulo 2^(operand width) and raise no flag.
- R7: req_size encodes the width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits.
- R8: Counters are big-endian in each 8-byte word. The byte at the lowest address is the most significant byte, so a 64-bit value 0x0102030405060708 at address A gives byte A+k the value k+1. A little-endian requester reaches the same counter by XORing its address with 7 (8-bit), 6 (16-bit) or 4 (32-bit).
- R9: A request whose address is not a multiple of the operand width in bytes produces rsp_valid=1, rsp_err=1 and rsp_old=0 one cycle later. This applies to both fetch-and-add and store requests, and the store is left unchanged.
- R10: Operations issued in consecutive cycles on the same or overlapping counters each see the result of the one before.
- R11: Bytes of the word outside the addressed counter are never changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears the store |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 0 = fetch-and-add, 1 = store-type |
| req_mode | input | 1 | Store-type only: 0 = add, 1 = overwrite |
| req_size | input | 2 | Operand width code |
| req_addr | input | ADDR_W | Byte address of the counter |
| req_operand | input | 64 | Increment (bits 21:0) or store data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Request was misaligned |
| rsp_old | output | 64 | Sign-extended previous value |

## Verification
The bench keeps its own byte array, assembles counters most-significant-byte first, and computes every expected old value and updated value arithmetically.

After reset, every word is read once to show it is zero. A sweep over all widths and all eight byte offsets then separates aligned requests from misaligned ones. The sweep uses increments at the extremes of the 22-bit range, with garbage in the upper operand bits, which shows whether sign extension and masking are right.

A known 64-bit pattern is read back byte by byte and through XOR-swizzled addresses, which tells a lane-placement error apart from an arithmetic one. Back-to-back operations on overlapping counters, and a long pseudo-random mix of sizes, modes and addresses packed into 64 bytes, expose stale data or bytes leaking across lanes.

// File: rtl/fau_pkg.sv
package fau_pkg;
  localparam int DATA_W = 64;
  localparam int INCR_W = 22;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } fau_size_e;

  // mask covering the low bytes of an operand of the given width
  function automatic logic [DATA_W-1:0] width_mask(fau_size_e sz);
    case (sz)
      SZ_B:    return 64'h0000_0000_0000_00FF;
      SZ_H:    return 64'h0000_0000_0000_FFFF;
      SZ_W:    return 64'h0000_0000_FFFF_FFFF;
      default: return '1;
    endcase
  endfunction

  function automatic logic is_aligned(fau_size_e sz, logic [2:0] off);
    case (sz)
      SZ_B:    return 1'b1;
      SZ_H:    return off[0] == 1'b0;
      SZ_W:    return off[1:0] == 2'b00;
      default: return off == 3'b000;
    endcase
  endfunction

  // bit position of the operand LSB inside a big-endian 8-byte word
  function automatic logic [5:0] lane_shift(fau_size_e sz, logic [2:0] off);
    int s;
    s = 8 * (8 - int'(off) - (1 << int'(sz)));
    return s[5:0];
  endfunction

  function automatic logic [DATA_W-1:0] sext_width(fau_size_e sz, logic [DATA_W-1:0] v);
    case (sz)
      SZ_B:    return {{56{v[7]}}, v[7:0]};
      SZ_H:    return {{48{v[15]}}, v[15:0]};
      SZ_W:    return {{32{v[31]}}, v[31:0]};
      default: return v;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] sext_incr(logic [INCR_W-1:0] i);
    return {{(DATA_W-INCR_W){i[INCR_W-1]}}, i};
  endfunction
endpackage

// File: rtl/fau_req_decode.sv
module fau_req_decode
  import fau_pkg::*;
#(
  parameter int ADDR_W = 11,
  localparam int WIDX_W = ADDR_W - 3
) (
  input  logic              req_valid,
  input  logic              req_store,
  input  logic              req_mode,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_operand,
  output logic [WIDX_W-1:0] word_idx,
  output logic [5:0]        lane_sh,
  output logic [DATA_W-1:0] lane_wmask,
  output logic [DATA_W-1:0] lane_opnd,
  output fau_size_e         lane_sz,
  output logic              wr_en,
  output logic              bad_align,
  output logic              overwrite
);
  logic [2:0] off;
  logic       ok;

  always_comb begin
    lane_sz    = fau_size_e'(req_size);
    off        = req_addr[2:0];
    word_idx   = req_addr[ADDR_W-1:3];
    ok         = is_aligned(lane_sz, off);
    lane_sh    = lane_shift(lane_sz, off);
    lane_wmask = width_mask(lane_sz);
    // fetch-and-add carries a short signed increment; stores carry full data
    lane_opnd  = (req_store ? req_operand : sext_incr(req_operand[INCR_W-1:0])) & lane_wmask;
    wr_en      = req_valid & ok;
    bad_align  = req_valid & ~ok;
    overwrite  = req_store & req_mode;
  end
endmodule

// File: rtl/fau_lane_alu.sv
module fau_lane_alu
  import fau_pkg::*;
(
  input  logic [DATA_W-1:0] old_word,
  input  logic [5:0]        lane_sh,
  input  logic [DATA_W-1:0] lane_wmask,
  input  logic [DATA_W-1:0] lane_opnd,
  input  fau_size_e         lane_sz,
  input  logic              overwrite,
  output logic [DATA_W-1:0] new_word,
  output logic [DATA_W-1:0] old_val
);
  logic [DATA_W-1:0] lane_old;
  logic [DATA_W-1:0] lane_new;

  always_comb begin
    lane_old = (old_word >> lane_sh) & lane_wmask;
    lane_new = overwrite ? lane_opnd : ((lane_old + lane_opnd) & lane_wmask);
    new_word = (old_word & ~(lane_wmask << lane_sh)) | (lane_new << lane_sh);
    old_val  = sext_width(lane_sz, lane_old);
  end
endmodule

// File: rtl/fau_regfile.sv
module fau_regfile
  import fau_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic              req_mode,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_operand,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_old
);
  localparam int WIDX_W    = ADDR_W - 3;
  localparam int NUM_WORDS = 1 << WIDX_W;

  logic [DATA_W-1:0] mem [NUM_WORDS];

  logic [WIDX_W-1:0] word_idx;
  logic [5:0]        lane_sh;
  logic [DATA_W-1:0] lane_wmask;
  logic [DATA_W-1:0] lane_opnd;
  fau_size_e         lane_sz;
  logic              wr_en;
  logic              bad_align;
  logic              overwrite;
  logic [DATA_W-1:0] old_word;
  logic [DATA_W-1:0] new_word;
  logic [DATA_W-1:0] old_val;

  fau_req_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid   (req_valid),
    .req_store   (req_store),
    .req_mode    (req_mode),
    .req_size    (req_size),
    .req_addr    (req_addr),
    .req_operand (req_operand),
    .word_idx    (word_idx),
    .lane_sh     (lane_sh),
    .lane_wmask  (lane_wmask),
    .lane_opnd   (lane_opnd),
    .lane_sz     (lane_sz),
    .wr_en       (wr_en),
    .bad_align   (bad_align),
    .overwrite   (overwrite)
  );

  assign old_word = mem[word_idx];

  fau_lane_alu u_alu (
    .old_word   (old_word),
    .lane_sh    (lane_sh),
    .lane_wmask (lane_wmask),
    .lane_opnd  (lane_opnd),
    .lane_sz    (lane_sz),
    .overwrite  (overwrite),
    .new_word   (new_word),
    .old_val    (old_val)
  );

  // read-modify-write completes in the accepting cycle: no forwarding path needed
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_old   <= '0;
    end else begin
      if (wr_en) mem[word_idx] <= new_word;
      rsp_valid <= (req_valid & ~req_store) | bad_align;
      rsp_err   <= bad_align;
      rsp_old   <= wr_en ? old_val : '0;
    end
  end

  // R2: every fetch-and-add gets a response in the next cycle
  p_load_responds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_store |=> rsp_valid);

  // R2: no response appears without a request one cycle earlier
  p_rsp_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  // R4: aligned stores stay silent
  p_store_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && req_store |=> !rsp_valid);

  // R5: overwrite places the operand in the addressed lane
  p_overwrite_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && overwrite |-> (((new_word >> lane_sh) & lane_wmask) == lane_opnd));

  // R9: misaligned request gives an error response with zero data
  p_misalign_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_align |=> rsp_valid && rsp_err && (rsp_old == '0));

  // R11: bytes outside the addressed lane are not disturbed
  p_keep_outside_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (((new_word ^ old_word) & ~(lane_wmask << lane_sh)) == '0));
endmodule

// File: tb/tb_fau_regfile.sv
module tb_fau_regfile;
  localparam int AW = 11;
  localparam int NB = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_store = 1'b0;
  logic          req_mode = 1'b0;
  logic [1:0]    req_size = '0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0]   req_operand = '0;
  logic          rsp_valid;
  logic          rsp_err;
  logic [63:0]   rsp_old;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [7:0] m [NB];
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  fau_regfile #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_mode(req_mode), .req_size(req_size), .req_addr(req_addr),
    .req_operand(req_operand), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_old(rsp_old)
  );

  function automatic logic [31:0] nxt(logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  // issue one request; compare the response one edge later against the byte model
  task automatic op(input bit st, input bit md, input int sz, input int a,
                    input logic [63:0] opnd, input string tag);
    int n;
    int w;
    bit bad;
    logic [63:0] old;
    logic [63:0] o;
    logic [63:0] nv;
    logic [63:0] exp_old;
    bit exp_v;
    n = 1 << sz;
    w = 8 * n;
    bad = (a % n) != 0;
    old = '0;
    if (!bad) for (int k = 0; k < n; k++) old = (old << 8) | 64'(m[a+k]);
    o  = st ? opnd : {{42{opnd[21]}}, opnd[21:0]};
    nv = (st && md) ? o : old + o;
    exp_old = old;
    if (w < 64 && old[w-1]) exp_old = old | ~((64'd1 << w) - 64'd1);
    if (bad) exp_old = '0;
    exp_v = !st || bad;
    req_valid = 1'b1; req_store = st; req_mode = md; req_size = 2'(sz);
    req_addr = AW'(a); req_operand = opnd;
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== exp_v || (exp_v && (rsp_err !== bad || rsp_old !== exp_old))) begin
      n_bad++;
      $display("FAIL %s: sz=%0d addr=%0d v/e/old=%0b/%0b/%h expected %0b/%0b/%h",
               tag, sz, a, rsp_valid, rsp_err, rsp_old, exp_v, bad, exp_old);
    end
    if (!bad) for (int k = 0; k < n; k++) m[a+k] = nv[8*(n-1-k) +: 8];
  endtask

  task automatic idle();
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: all words read zero after reset
    for (int i = 0; i < NB / 8; i++) op(0, 0, 3, i * 8, 64'd0, "R1");
    idle();
    // R7 R9 R3 R6 R2: sweep every width and offset with extreme increments
    for (int sz = 0; sz < 4; sz++)
      for (int off = 0; off < 8; off++) begin
        op(0, 1, sz, 64 + off, 64'hDEAD_BEEF_C01F_FFFF, "R3");
        op(0, 0, sz, 64 + off, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
        op(0, 0, sz, 64 + off, 64'h0000_0000_0020_0000, "R2");
      end
    idle();
    // R6: byte counter wraps past its maximum
    op(1, 1, 0, 200, 64'h7F, "R5");
    op(0, 0, 0, 200, 64'h1, "R6");
    op(0, 0, 0, 200, 64'h7F, "R6");
    op(0, 0, 0, 200, 64'h0, "R6");
    // R8: big-endian lane placement and XOR-swizzled access
    op(1, 1, 3, 256, 64'h0102_0304_0506_0708, "R5");
    for (int k = 0; k < 8; k++) op(0, 0, 0, 256 + k, 64'd0, "R8");
    op(0, 0, 2, (256 + 0) ^ 4, 64'd0, "R8");
    op(0, 0, 1, (256 + 0) ^ 6, 64'd0, "R8");
    op(0, 0, 0, (256 + 0) ^ 7, 64'd0, "R8");
    // R4: store-add of full data, only low bytes used
    op(1, 0, 1, 258, 64'hFFFF_FFFF_FFFF_0101, "R4");
    op(0, 0, 3, 256, 64'd0, "R4");
    // R11: overwrite one byte in the middle, rest of word intact
    op(1, 1, 0, 259, 64'hAA, "R11");
    op(0, 0, 3, 256, 64'd0, "R11");
    // R9: misaligned stores and loads leave storage unchanged
    op(1, 1, 3, 260, 64'h1111_2222_3333_4444, "R9");
    op(1, 0, 1, 257, 64'h5555, "R9");
    op(0, 0, 2, 258, 64'd5, "R9");
    op(0, 0, 3, 256, 64'd0, "R9");
    // R10: back-to-back on overlapping counters
    op(0, 0, 0, 263, 64'd3, "R10");
    op(0, 0, 1, 262, 64'd7, "R10");
    op(0, 0, 3, 256, 64'h3F_FFFF, "R10");
    op(1, 0, 2, 260, 64'h1, "R10");
    op(0, 0, 3, 256, 64'd0, "R10");
    idle();
    // R7 R10: pseudo-random mix packed into 64 bytes
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] d;
      seed = nxt(seed); d[31:0] = seed;
      seed = nxt(seed); d[63:32] = seed;
      seed = nxt(seed);
      op(seed[20], seed[21], int'(seed[23:22]), 512 + int'(seed[29:24]), d, "R7");
    end
    idle();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule